// File: doc/BRIEF.md
# Timer-Driven Multi-Mode Compare Output Channel

This block drives one output pin from a free-running 16-bit count. The count comes from one of several timer count inputs or from the system clock count. Each cycle the selected count is compared with a primary and a secondary compare value. A 3-bit mode decides what those matches do to the pin. The modes cover one-shot set and clear, toggle on match, two dual-compare pulse styles, and two PWM styles.

In the two PWM modes, compare writes are held in a shadow copy and reach the comparators only at the period boundary, when the count equals zero. In every other mode they take effect at once. A fault input can force the pin low in the PWM modes. That fault state is held until the fault input drops and a new period starts. A trigger status flag is set from outside. It can be cleared by software or, when enabled, by a secondary match. An idle input can freeze the channel. A one-cycle event pulse marks each compare match.

Top module: `cmp_out_chan`

## Requirements
- R1: After reset, pin_o, fault_o, trig_o and event_o are all 0.
- R2: mode_i=001 drives the pin low on entry and high on the first primary match, and it then holds. mode_i=010 drives the pin high on entry and low on the first primary match, and it then holds. The edge that applies a new mode only sets the entry level and does no matching.
- R3: mode_i=011 drives the pin low on entry, then inverts it on every primary match.
- R4: mode_i=100 drives the pin low on entry. A primary match takes it high, and a later secondary match takes it low for good.
- R5: mode_i=101 drives the pin low on entry. The pin goes high on a primary match while low and goes low on a secondary match while high, repeating indefinitely.
- R6: mode_i=110 (edge PWM) drives the pin high on the count-zero edge and low on a secondary match. A secondary match wins over the zero edge. With period P the pin is high after count c exactly when c < secondary.
- R7: mode_i=111 (center PWM) drives the pin high on a primary match and low on a secondary match. The secondary match wins when both occur.
- R8: In modes 110 and 111, compare writes take effect only on the next count-zero edge. In all other modes a write is used from the following cycle.
- R9: In modes 110 and 111, a fault (fault_i=1 with fault_en_i=1) sets fault_o and forces the pin low on the same edge. fault_o clears only on a count-zero edge with fault_i=0. In other modes, or with fault_en_i=0, fault_o stays 0.
- R10: trig_set_i sets trig_o. trig_clr_i clears it. With trig_auto_i=1, a secondary match also clears it. With trig_auto_i=0, it stays set until trig_clr_i. A clear wins over a set on the same edge.
- R11: With halt_idle_i=1 and idle_i=1, the channel freezes: no matching, the pin holds, and no events. With halt_idle_i=0, idle_i has no effect.
- R12: tb_sel_i values 0 to 4 select timer count 0 to 4. Value 7 selects sys_cnt_i. Values 5 and 6 select nothing, so no match ever occurs.
- R13: event_o pulses for one cycle after each edge with a primary match (modes 001 to 011) or a primary or secondary match (modes 100 to 111).
- R14: mode_i=000 drives the pin low on the next edge and keeps it low. The compare values are kept across the disabled period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Operating mode |
| tb_sel_i | input | 3 | Time-base select |
| tmr_cnt_i | input | NTMR*CW | Timer counts, timer k in bits [k*CW +: CW] |
| sys_cnt_i | input | CW | System clock count |
| pri_we_i | input | 1 | Primary compare write strobe |
| pri_wdata_i | input | CW | Primary compare write data |
| sec_we_i | input | 1 | Secondary compare write strobe |
| sec_wdata_i | input | CW | Secondary compare write data |
| fault_en_i | input | 1 | Fault input enable |
| fault_i | input | 1 | Fault input |
| idle_i | input | 1 | CPU idle indication |
| halt_idle_i | input | 1 | Freeze while idle |
| trig_set_i | input | 1 | Set trigger status |
| trig_clr_i | input | 1 | Software clear of trigger status |
| trig_auto_i | input | 1 | Enable clear of trigger status on secondary match |
| pin_o | output | 1 | Compare output pin |
| fault_o | output | 1 | Fault latched status |
| trig_o | output | 1 | Trigger status |
| event_o | output | 1 | Compare event pulse |

## Verification
The bench uses a 4-bit count that wraps every 16 cycles.

- **Single-compare and dual-compare modes.** The primary value is swept over every count, and primary/secondary pairs are tried on both sides of each other. This separates a primary-before-secondary pulse from one that wraps across the count boundary.
- **PWM modes.** Every duty and every compare pair is swept, including equal values. This shows which edge wins when two events coincide. A write placed in mid-period separates shadowed writes from immediate ones.
- **Time-base select.** Each select code is tried with only the chosen source counting. This exposes a wrong or reserved mapping.
- **Fault, idle and trigger controls.** Each is toggled against a running pattern, so its effect is visible at the pin or at the status outputs.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [2:0] {
    MD_OFF      = 3'b000,
    MD_SET_HI   = 3'b001,
    MD_SET_LO   = 3'b010,
    MD_TOGGLE   = 3'b011,
    MD_DUAL_ONE = 3'b100,
    MD_DUAL_RUN = 3'b101,
    MD_PWM_EDGE = 3'b110,
    MD_PWM_CTR  = 3'b111
  } mode_e;

  function automatic logic is_pwm(mode_e m);
    return m[2] & m[1];
  endfunction
endpackage

// File: rtl/tbase_mux.sv
module tbase_mux #(
  parameter int CW   = 16,
  parameter int NTMR = 5,
  parameter int SW   = 3
) (
  input  logic [SW-1:0]      sel_i,
  input  logic [NTMR*CW-1:0] tmr_cnt_i,
  input  logic [CW-1:0]      sys_cnt_i,
  output logic [CW-1:0]      cnt_o,
  output logic               vld_o
);
  localparam logic [SW-1:0] SYS_CODE = {SW{1'b1}};

  always_comb begin
    cnt_o = '0;
    vld_o = 1'b0;
    if (sel_i == SYS_CODE) begin
      cnt_o = sys_cnt_i;
      vld_o = 1'b1;
    end else begin
      for (int k = 0; k < NTMR; k++) begin
        if (sel_i == SW'(k)) begin
          cnt_o = tmr_cnt_i[k*CW +: CW];
          vld_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwm_i,
  input  logic          load_i,
  input  logic          pri_we_i,
  input  logic [CW-1:0] pri_wdata_i,
  input  logic          sec_we_i,
  input  logic [CW-1:0] sec_wdata_i,
  output logic [CW-1:0] pri_act_o,
  output logic [CW-1:0] sec_act_o,
  output logic [CW-1:0] pri_buf_o,
  output logic [CW-1:0] sec_buf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_buf_o <= '0;
      sec_buf_o <= '0;
      pri_act_o <= '0;
      sec_act_o <= '0;
    end else begin
      if (pri_we_i) pri_buf_o <= pri_wdata_i;
      if (sec_we_i) sec_buf_o <= sec_wdata_i;
      // shadowed only in PWM; transfer at period boundary
      if (pri_we_i && !pwm_i) pri_act_o <= pri_wdata_i;
      else if (load_i)        pri_act_o <= pri_buf_o;
      if (sec_we_i && !pwm_i) sec_act_o <= sec_wdata_i;
      else if (load_i)        sec_act_o <= sec_buf_o;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i && !load_i |=> $stable(pri_act_o) && $stable(sec_act_o)); // R8
  AST_DIRECT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_i && pri_we_i |=> pri_act_o == $past(pri_wdata_i)); // R8
endmodule

// File: rtl/pin_ctl.sv
module pin_ctl
  import ocu_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  mode_e         mode_i,
  input  logic          run_i,
  input  logic          vld_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] pri_i,
  input  logic [CW-1:0] sec_i,
  input  logic          fault_en_i,
  input  logic          fault_i,
  output logic          pin_o,
  output logic          fault_o,
  output logic          event_o,
  output logic          sec_hit_o
);
  mode_e mode_q;
  logic  done_q, pin_n, done_n, flt_n, evt_n;
  logic  chg, pm, sm, wrap, pwm, flt_set;

  assign chg       = mode_i != mode_q;
  assign pm        = run_i && vld_i && (cnt_i == pri_i);
  assign sm        = run_i && vld_i && (cnt_i == sec_i);
  assign wrap      = run_i && vld_i && (cnt_i == '0);
  assign pwm       = is_pwm(mode_i);
  assign flt_set   = pwm && fault_en_i && fault_i;
  assign sec_hit_o = sm;

  always_comb begin
    flt_n = fault_o;
    if (chg || !pwm)          flt_n = 1'b0;
    else if (wrap && !fault_i) flt_n = 1'b0;
    if (flt_set)              flt_n = 1'b1;

    pin_n  = pin_o;
    done_n = done_q;
    evt_n  = 1'b0;
    if (chg) begin
      pin_n  = (mode_i == MD_SET_LO);
      done_n = 1'b0;
    end else begin
      case (mode_i)
        MD_OFF:      pin_n = 1'b0;
        MD_SET_HI:   if (pm && !done_q) begin pin_n = 1'b1; done_n = 1'b1; end
        MD_SET_LO:   if (pm && !done_q) begin pin_n = 1'b0; done_n = 1'b1; end
        MD_TOGGLE:   if (pm) pin_n = !pin_o;
        MD_DUAL_ONE: if (!done_q) begin
                       if (pm && !pin_o)     pin_n = 1'b1;
                       else if (sm && pin_o) begin pin_n = 1'b0; done_n = 1'b1; end
                     end
        MD_DUAL_RUN: if (pm && !pin_o)      pin_n = 1'b1;
                     else if (sm && pin_o) pin_n = 1'b0;
        MD_PWM_EDGE: begin
                       if (wrap) pin_n = 1'b1;
                       if (sm)   pin_n = 1'b0;
                     end
        MD_PWM_CTR:  begin
                       if (pm) pin_n = 1'b1;
                       if (sm) pin_n = 1'b0;
                     end
        default:     pin_n = 1'b0;
      endcase
      if (mode_i != MD_OFF) evt_n = mode_i[2] ? (pm || sm) : pm;
    end
    if (flt_n) pin_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MD_OFF;
      pin_o   <= 1'b0;
      done_q  <= 1'b0;
      fault_o <= 1'b0;
      event_o <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      pin_o   <= pin_n;
      done_q  <= done_n;
      fault_o <= flt_n;
      event_o <= evt_n;
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MD_OFF |=> !pin_o); // R14
  AST_FAULT_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !pin_o); // R9
  AST_FROZEN_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !chg && !flt_set |=> $stable(pin_o)); // R11
  AST_FROZEN_NO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !event_o); // R13
  AST_SHOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !chg |=> $stable(pin_o)); // R2
endmodule

// File: rtl/trig_flag.sv
module trig_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic auto_i,
  input  logic hit_i,
  output logic trig_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      trig_o <= 1'b0;
    else if (clr_i || (auto_i && hit_i)) trig_o <= 1'b0;
    else if (set_i)                   trig_o <= 1'b1;
  end

  AST_TRIG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o && !clr_i && !auto_i |=> trig_o); // R10
endmodule

// File: rtl/cmp_out_chan.sv
module cmp_out_chan
  import ocu_pkg::*;
#(
  parameter int CW   = 16,
  parameter int NTMR = 5,
  parameter int SW   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         mode_i,
  input  logic [SW-1:0]      tb_sel_i,
  input  logic [NTMR*CW-1:0] tmr_cnt_i,
  input  logic [CW-1:0]      sys_cnt_i,
  input  logic               pri_we_i,
  input  logic [CW-1:0]      pri_wdata_i,
  input  logic               sec_we_i,
  input  logic [CW-1:0]      sec_wdata_i,
  input  logic               fault_en_i,
  input  logic               fault_i,
  input  logic               idle_i,
  input  logic               halt_idle_i,
  input  logic               trig_set_i,
  input  logic               trig_clr_i,
  input  logic               trig_auto_i,
  output logic               pin_o,
  output logic               fault_o,
  output logic               trig_o,
  output logic               event_o
);
  mode_e         mode;
  logic          run, vld, pwm, at_zero, load, sec_hit;
  logic [CW-1:0] cnt, pri_act, sec_act, pri_buf, sec_buf, pri_eff, sec_eff;

  assign mode    = mode_e'(mode_i);
  assign run     = !(halt_idle_i && idle_i);
  assign pwm     = is_pwm(mode);
  assign at_zero = vld && (cnt == '0);
  assign load    = pwm && run && at_zero;
  // at the boundary the comparators see the values being loaded
  assign pri_eff = load ? pri_buf : pri_act;
  assign sec_eff = load ? sec_buf : sec_act;

  tbase_mux #(.CW(CW), .NTMR(NTMR), .SW(SW)) i_tbase_mux (
    .sel_i(tb_sel_i), .tmr_cnt_i(tmr_cnt_i), .sys_cnt_i(sys_cnt_i),
    .cnt_o(cnt), .vld_o(vld)
  );

  cmp_regs #(.CW(CW)) i_cmp_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm), .load_i(load),
    .pri_we_i(pri_we_i), .pri_wdata_i(pri_wdata_i),
    .sec_we_i(sec_we_i), .sec_wdata_i(sec_wdata_i),
    .pri_act_o(pri_act), .sec_act_o(sec_act),
    .pri_buf_o(pri_buf), .sec_buf_o(sec_buf)
  );

  pin_ctl #(.CW(CW)) i_pin_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .run_i(run),
    .vld_i(vld), .cnt_i(cnt), .pri_i(pri_eff), .sec_i(sec_eff),
    .fault_en_i(fault_en_i), .fault_i(fault_i),
    .pin_o(pin_o), .fault_o(fault_o), .event_o(event_o), .sec_hit_o(sec_hit)
  );

  trig_flag i_trig_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(trig_set_i), .clr_i(trig_clr_i),
    .auto_i(trig_auto_i), .hit_i(sec_hit), .trig_o(trig_o)
  );

  AST_NO_FAULT_NON_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm |=> !fault_o); // R9
  AST_RESERVED_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld && !pri_we_i && !sec_we_i && mode == MD_TOGGLE && $stable(mode_i) |=> !event_o); // R12
endmodule

// File: tb/test_cmp_out_chan.sv
`timescale 1ns/1ps
module test_cmp_out_chan;
  localparam int CW = 4, NTMR = 5, SW = 3;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0, sel = 0;
  logic [NTMR*CW-1:0] tmr = '0;
  logic [CW-1:0] sys = '0, pri_wd = '0, sec_wd = '0;
  logic pri_we = 0, sec_we = 0, flt_en = 0, flt = 0, idle = 0, halt = 0;
  logic tset = 0, tclr = 0, tauto = 0;
  logic pin, fault, trig, evt;

  int nv = 0, nerr = 0, cnt = 0, last_c = 0;
  logic [5:0] mask = 6'h3F;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmp_out_chan #(.CW(CW), .NTMR(NTMR), .SW(SW)) i_cmp_out_chan (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .tb_sel_i(sel),
    .tmr_cnt_i(tmr), .sys_cnt_i(sys),
    .pri_we_i(pri_we), .pri_wdata_i(pri_wd), .sec_we_i(sec_we), .sec_wdata_i(sec_wd),
    .fault_en_i(flt_en), .fault_i(flt), .idle_i(idle), .halt_idle_i(halt),
    .trig_set_i(tset), .trig_clr_i(tclr), .trig_auto_i(tauto),
    .pin_o(pin), .fault_o(fault), .trig_o(trig), .event_o(evt)
  );

  task automatic chk(string req, logic got, logic exp);
    nv++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0b expected %0b (count %0d)", req, got, exp, last_c);
    end
  endtask

  task automatic tick();
    for (int k = 0; k < NTMR; k++) tmr[k*CW +: CW] = mask[k] ? CW'(cnt) : CW'(9);
    sys = mask[5] ? CW'(cnt) : CW'(9);
    last_c = cnt;
    @(posedge clk);
    cnt = (cnt + 1) % 16;
    @(negedge clk);
  endtask

  task automatic wait_cnt(int v);
    while (cnt != v) tick();
  endtask

  task automatic wr(int p, int s, bit dp, bit ds);
    pri_we = dp; sec_we = ds; pri_wd = CW'(p); sec_wd = CW'(s);
    tick();
    pri_we = 0; sec_we = 0;
  endtask

  task automatic set_mode(int m);
    mode = 3'(m);
    tick();
  endtask

  function automatic bit ctr_hi(int a, int b, int c);
    if (a < b) return (c >= a) && (c < b);
    if (a > b) return (c >= a) || (c < b);
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nv, nerr);
      $finish;
    end
  end

  initial begin
    bit seen, p, hi, dn, wrapped;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin", pin, 0); chk("R1 fault", fault, 0);
    chk("R1 trig", trig, 0); chk("R1 event", evt, 0);

    // R2 single-compare one-shots, every primary value
    for (int a = 0; a < 16; a++) begin
      for (int md = 1; md <= 2; md++) begin
        set_mode(0);
        wr(a, 0, 1, 0);
        set_mode(md);
        chk("R2 entry level", pin, md == 2);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
          tick();
          if (last_c == a) seen = 1;
          chk("R2 one-shot", pin, (md == 1) ? seen : !seen);
        end
      end
    end

    // R3 toggle, R13 event pulses
    for (int a = 0; a < 16; a += 5) begin
      set_mode(0);
      wr(a, 0, 1, 0);
      set_mode(3);
      p = 0;
      chk("R3 entry", pin, 0);
      for (int i = 0; i < 36; i++) begin
        tick();
        if (last_c == a) p = !p;
        chk("R3 toggle", pin, p);
        chk("R13 event", evt, last_c == a);
      end
    end

    // R4 dual-compare single shot
    for (int a = 0; a < 15; a += 3) begin
      for (int b = a + 1; b < 16; b += 4) begin
        set_mode(0);
        wr(a, b, 1, 1);
        set_mode(4);
        hi = 0; dn = 0;
        for (int i = 0; i < 40; i++) begin
          tick();
          if (!dn) begin
            if (last_c == a && !hi) hi = 1;
            else if (last_c == b && hi) begin hi = 0; dn = 1; end
          end
          chk("R4 dual one-shot", pin, hi);
          chk("R13 event dual", evt, last_c == a || last_c == b);
        end
      end
    end

    // R5 dual-compare continuous, both orderings
    for (int a = 0; a < 16; a += 3) begin
      for (int b = 1; b < 16; b += 5) begin
        if (a == b) continue;
        set_mode(0);
        wr(a, b, 1, 1);
        set_mode(5);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
          tick();
          if (last_c == a) seen = 1;
          chk("R5 dual continuous", pin, seen ? ctr_hi(a, b, last_c) : 1'b0);
        end
      end
    end

    // R6 edge PWM, every duty
    set_mode(0);
    set_mode(6);
    for (int d = 0; d < 16; d++) begin
      wr(0, d, 0, 1);
      repeat (32) tick();
      for (int i = 0; i < 16; i++) begin
        tick();
        chk("R6 edge pwm", pin, last_c < d);
      end
    end

    // R7 center PWM, every pair
    set_mode(0);
    set_mode(7);
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(a, b, 1, 1);
        repeat (32) tick();
        for (int i = 0; i < 16; i++) begin
          tick();
          chk("R7 center pwm", pin, ctr_hi(a, b, last_c));
        end
      end
    end

    // R8 shadowed write in PWM takes effect at the next zero count
    set_mode(0);
    set_mode(6);
    wr(0, 4, 0, 1);
    repeat (32) tick();
    wait_cnt(1);
    wr(0, 12, 0, 1);
    wrapped = 0;
    for (int i = 0; i < 32; i++) begin
      tick();
      if (last_c == 0) wrapped = 1;
      chk("R8 shadowed duty", pin, last_c < (wrapped ? 12 : 4));
    end
    // R8 immediate write outside PWM
    set_mode(0);
    wr(10, 0, 1, 0);
    set_mode(3);
    wait_cnt(3);
    p = pin;
    wr(4, 0, 1, 0);
    chk("R8 no early toggle", pin, p);
    tick();
    chk("R8 immediate write", pin, !p);

    // R9 fault in PWM
    set_mode(0);
    set_mode(6);
    wr(0, 8, 0, 1);
    flt_en = 1;
    repeat (32) tick();
    wait_cnt(3);
    flt = 1;
    tick();
    chk("R9 fault set", fault, 1); chk("R9 pin forced", pin, 0);
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R9 fault held", fault, 1); chk("R9 pin held low", pin, 0);
    end
    flt = 0;
    do begin
      tick();
      chk("R9 release only at zero", fault, last_c != 0);
      chk("R9 pin after release", pin, last_c == 0);
    end while (last_c != 0);
    for (int i = 0; i < 7; i++) begin
      tick();
      chk("R9 resumes", pin, last_c < 8);
    end
    flt_en = 0; flt = 1;
    for (int i = 0; i < 16; i++) begin
      tick();
      chk("R9 disabled fault", fault, 0); chk("R9 disabled pin", pin, last_c < 8);
    end
    flt_en = 1;
    set_mode(3);
    repeat (5) tick();
    chk("R9 non-pwm no fault", fault, 0);
    flt = 0; flt_en = 0;

    // R10 trigger status
    set_mode(0);
    wr(0, 6, 0, 1);
    set_mode(3);
    tauto = 1;
    wait_cnt(8);
    tset = 1; tick(); tset = 0;
    chk("R10 set", trig, 1);
    do begin
      tick();
      chk("R10 auto clear", trig, last_c != 6);
    end while (last_c != 6);
    tauto = 0;
    tset = 1; tick(); tset = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R10 no auto clear", trig, 1);
    end
    tclr = 1; tick(); tclr = 0;
    chk("R10 sw clear", trig, 0);
    tset = 1; tclr = 1; tick(); tset = 0; tclr = 0;
    chk("R10 clear wins", trig, 0);

    // R11 idle freeze
    set_mode(0);
    wr(2, 0, 1, 0);
    set_mode(3);
    halt = 1; idle = 1;
    p = pin;
    for (int i = 0; i < 40; i++) begin
      tick();
      chk("R11 frozen pin", pin, p); chk("R11 frozen event", evt, 0);
    end
    halt = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (last_c == 2) p = !p;
      chk("R11 idle ignored", pin, p);
    end
    idle = 0;

    // R12 time-base select
    for (int code = 0; code < 8; code++) begin
      set_mode(0);
      sel = 3'(code);
      if (code < 5) mask = 6'(1 << code);
      else if (code == 7) mask = 6'h20;
      else mask = 6'h3F;
      wr(5, 0, 1, 0);
      set_mode(1);
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        tick();
        if (last_c == 5 && (code < 5 || code == 7)) seen = 1;
        chk("R12 select", pin, seen);
      end
    end
    mask = 6'h3F; sel = 0;

    // R14 disable drives low and keeps compare values
    set_mode(0);
    wr(5, 0, 1, 0);
    set_mode(3);
    wait_cnt(6);
    chk("R14 precondition high", pin, 1);
    set_mode(0);
    chk("R14 low at once", pin, 0);
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R14 stays low", pin, 0); chk("R14 no event", evt, 0);
    end
    set_mode(1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (last_c == 5) seen = 1;
      chk("R14 value kept", pin, seen);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nv, nerr);
    $finish;
  end
endmodule